// File: doc/BRIEF.md
# MDIO master with PHY autoscan

This block is a management-interface master for external PHYs. It produces the management clock (MDC) from the system clock and sends Clause 22 frames on a bidirectional data pin. The pin is split into a driven value, a sampled value and an output enable. Software starts single read or write frames by writing a command word into a small register file. A status bit reports that a command is pending or in flight. A second bit controls whether that status bit is visible.

With background polling switched on, the block reads the basic status register (register 1) of each eligible PHY address in turn. It copies link bit 2 of each answer into a per-port link output. Port p is polled at PHY address p. A port is eligible when its bit in the address-enable register is set and its copper-mode input is high.

A software command always takes the next free frame slot. Once the command has finished, polling continues with the address that follows the last one polled. One control bit selects between a slow and a fast MDC rate.

Top module: `mdio_scan_master`

## Requirements
- R1: Each frame is 32 ones, start 01, opcode (10 = read, 01 = write), 5-bit PHY address, 5-bit register address, turnaround and 16 data bits, all sent MSB first. A write frame drives turnaround 10 and then its data. A read frame releases the pin (enable low) for the turnaround and data bits. The pin stays released for at least one MDC period between frames.
- R2: The data pin and its enable change only together with a falling MDC edge. Read data is sampled at the rising edges. The read-data register (address 3, bits 15:0) changes only when a read frame ends, and a write frame leaves it unchanged.
- R3: With rate bit 0 the MDC period is 2*HALF_SLOW system clocks (20 by default). With rate bit 1 it is 2*HALF_FAST system clocks (4 by default).
- R4: Control register at address 0: bit0 rate, bit1 polling enable, bit2 busy-report enable, bit3 busy (read-only). These bits reset to 0. Address-enable register at address 1: bits NPORT-1:0, reset to all ones. Bits 31:4 of both registers read as 0 and ignore writes.
- R5: Busy is 1 from the clock after a command write until that command's frame ends. It is read as control bit3 only while bit2 is set, and bit3 reads 0 otherwise.
- R6: A write to the command register (address 2: bit26 = 1 read / 0 write, bits 25:21 PHY, bits 20:16 register, bits 15:0 write data) while busy is 1 is ignored. It starts no frame and does not change the stored command that is read back at address 2.
- R7: Polling is off after reset. When on, it reads register 1 of the eligible addresses in ascending order with wrap-around, starting from address 0. It stores bit 2 of each answer in link_up of that port. When polling is switched off, no new poll frame starts.
- R8: A port whose enable bit or copper_mode input is low is not polled, and its link_up bit holds its value.
- R9: A pending command starts at the next frame boundary, ahead of polling. Polling then continues at the address after the last one polled before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin value when driven |
| mdio_oe | output | 1 | Data pin drive enable |
| mdio_i | input | 1 | Data pin sampled value |
| copper_mode | input | NPORT | Per-port copper mode, gates polling |
| link_up | output | NPORT | Per-port link state from polling |

## Verification
A PHY model in the bench decodes every frame from the pin and answers reads with a value built from the address pair. Reads across different address pairs and writes with all-ones and mixed data separate correct bit ordering from swapped or shifted fields. Alternating reads and writes shows that a write frame leaves the read-data register alone. Polling runs with one port out of copper mode and then with a reduced enable mask while link states change. The polling order and the held link bits then distinguish the eligibility mask from a plain address sweep. A command issued during polling, followed by a second command while the first is still busy, separates frame-boundary priority and resume order from preemption or command queuing.

// File: rtl/mdio_pkg.sv
// Package: shared command type and frame builder for the MDIO master.
// Assumes Clause 22 framing only; the frame is always 64 MDC periods long.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = PRE_BITS + 2 + 2 + 5 + 5;
    localparam int DATA_POS   = TA_POS + 2;
    localparam int LAST_POS   = DATA_POS + 15;
    localparam logic [4:0] STATUS_REG = 5'd1;
    localparam int LINK_BIT   = 2;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    // Assemble the serial image of one frame, first bit in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        return {{PRE_BITS{1'b1}}, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad,
                (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : c.data)};
    endfunction
endpackage

// File: rtl/mdc_gen.sv
// MDC generator: divides the system clock by one of two half-period counts.
// Emits one-cycle pulses in the cycle where MDC is about to rise or fall.
// Assumes HALF_SLOW and HALF_FAST are at least 1.
module mdc_gen #(
    parameter int HALF_SLOW = 10,
    parameter int HALF_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          tick;

    // Terminal count for the selected rate; >= tolerates a rate switch.
    assign limit     = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
    assign tick      = (cnt >= limit);
    assign rise_tick = tick & ~mdc;
    assign fall_tick = tick & mdc;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame.sv
// Frame engine: shifts one Clause 22 frame out on MDC falling ticks and
// collects read data on rising ticks. A start is taken only on a falling
// tick while idle, so at least one idle MDC period separates frames.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        mdio_i,
    output logic        accept,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    logic                  active;
    logic                  rd_q;
    logic [5:0]            bitn;
    logic [FRAME_BITS-1:0] sh;

    assign accept  = start & ~active & fall_tick;
    assign done    = active & fall_tick & (bitn == 6'(LAST_POS));
    assign mdio_o  = active ? sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = active & (~rd_q | (bitn < 6'(TA_POS)));

    // Frame sequencing and serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            rd_q   <= 1'b0;
            bitn   <= '0;
            sh     <= '1;
        end else if (accept) begin
            active <= 1'b1;
            rd_q   <= cmd.rd;
            bitn   <= '0;
            sh     <= build_frame(cmd);
        end else if (done) begin
            active <= 1'b0;
        end else if (active && fall_tick) begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[FRAME_BITS-2:0], 1'b1};
        end
    end

    // Read data capture on rising ticks of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (active && rise_tick && rd_q && (bitn >= 6'(DATA_POS))) begin
            rd_data <= {rd_data[14:0], mdio_i};
        end
    end
endmodule

// File: rtl/scan_pick.sv
// Round-robin picker: the first set bit of elig at or after ptr, with wrap.
// Purely combinational; any is low when no bit is set.
module scan_pick #(
    parameter int NPORT = 4,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] elig,
    input  logic [PW-1:0]    ptr,
    output logic             any,
    output logic [PW-1:0]    pick
);
    // Walk from the farthest offset down so the nearest eligible port wins.
    always_comb begin
        any  = 1'b0;
        pick = ptr;
        for (int k = NPORT - 1; k >= 0; k--) begin
            if (elig[(int'(ptr) + k) % NPORT]) begin
                any  = 1'b1;
                pick = PW'((int'(ptr) + k) % NPORT);
            end
        end
    end
endmodule

// File: rtl/mdio_scan_master.sv
// MDIO master top: register file, command/poll arbitration and link record.
// Assumes port p is polled at PHY address p and NPORT <= 28.
module mdio_scan_master
    import mdio_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int HALF_SLOW = 10,
    parameter int HALF_FAST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i,
    input  logic [NPORT-1:0] copper_mode,
    output logic [NPORT-1:0] link_up
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic             rate_q, scan_q, brpt_q;
    logic [NPORT-1:0] aen_q;
    mdio_cmd_t        cmd_q;
    logic             pend_q, cmd_run_q;
    logic [15:0]      rdd_q;
    logic [PW-1:0]    ptr_q, own_port_q;
    logic [NPORT-1:0] link_q;
    logic [NPORT-1:0] elig;
    logic             any_elig, sel_cmd, start, accept, fdone;
    logic [PW-1:0]    pick;
    logic             rise_tick, fall_tick;
    logic [15:0]      frd;
    mdio_cmd_t        fcmd;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[31:27];
    assign elig    = aen_q & copper_mode;
    assign sel_cmd = pend_q & ~cmd_run_q;
    assign start   = sel_cmd | (scan_q & any_elig);
    assign link_up = link_q;

    // Frame source: the pending command, else a status poll of the picked port.
    always_comb begin
        if (sel_cmd) begin
            fcmd = cmd_q;
        end else begin
            fcmd.rd    = 1'b1;
            fcmd.phy   = 5'(pick);
            fcmd.regad = STATUS_REG;
            fcmd.data  = '0;
        end
    end

    mdc_gen #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_mdc (
        .clk(clk), .rst_n(rst_n), .fast(rate_q),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .start(start), .cmd(fcmd), .mdio_i(mdio_i), .accept(accept),
        .done(fdone), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(frd)
    );

    scan_pick #(.NPORT(NPORT)) u_pick (
        .elig(elig), .ptr(ptr_q), .any(any_elig), .pick(pick)
    );

    // Control and address-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
            scan_q <= 1'b0;
            brpt_q <= 1'b0;
            aen_q  <= '1;
        end else if (reg_we) begin
            if (reg_addr == 2'd0) begin
                rate_q <= reg_wdata[0];
                scan_q <= reg_wdata[1];
                brpt_q <= reg_wdata[2];
            end
            if (reg_addr == 2'd1) aen_q <= reg_wdata[NPORT-1:0];
        end
    end

    // Software command: accept when idle, track its frame, keep read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            pend_q    <= 1'b0;
            cmd_run_q <= 1'b0;
            rdd_q     <= '0;
        end else begin
            if (reg_we && reg_addr == 2'd2 && !pend_q) begin
                cmd_q  <= reg_wdata[26:0];
                pend_q <= 1'b1;
            end
            if (accept && sel_cmd) cmd_run_q <= 1'b1;
            if (fdone && cmd_run_q) begin
                pend_q    <= 1'b0;
                cmd_run_q <= 1'b0;
                if (cmd_q.rd) rdd_q <= frd;
            end
        end
    end

    // Poll bookkeeping: remember the polled port, store its link, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            own_port_q <= '0;
            link_q     <= '0;
        end else begin
            if (accept && !sel_cmd) own_port_q <= pick;
            if (fdone && !cmd_run_q) begin
                if (elig[own_port_q]) link_q[own_port_q] <= frd[LINK_BIT];
                ptr_q <= (own_port_q == PW'(NPORT - 1)) ? '0 : own_port_q + 1'b1;
            end
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {28'b0, pend_q & brpt_q, brpt_q, scan_q, rate_q};
            2'd1:    reg_rdata = {{(32-NPORT){1'b0}}, aen_q};
            2'd2:    reg_rdata = {5'b0, cmd_q};
            default: reg_rdata = {16'b0, rdd_q};
        endcase
    end
endmodule

// File: rtl/mdio_scan_checker.sv
// Checker: temporal properties of the MDIO master, bound into the top.
module mdio_scan_checker #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic [NPORT-1:0] link_up,
    input logic [NPORT-1:0] elig,
    input logic             pend,
    input logic [26:0]      cmd,
    input logic [15:0]      rdd,
    input logic             frame_done
);
    // R2: pin value and enable move only with a falling MDC edge.
    p_mdio_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mdio_o, mdio_oe}) |-> $fell(mdc));

    // R2: read-data register changes only right after a frame end.
    p_rdd_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdd) |-> $past(frame_done));

    // R4: upper bits of both control registers read zero.
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr <= 2'd1) |-> (reg_rdata[31:4] == 28'd0));

    // R5: busy is hidden while the report enable is clear.
    p_busy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0 && !reg_rdata[2]) |-> !reg_rdata[3]);

    // R6: a command write while busy leaves the stored command alone.
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && reg_we && reg_addr == 2'd2) |=> $stable(cmd));

    // R8: link bits of ineligible ports never move.
    p_link_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (((link_up ^ $past(link_up)) & ~$past(elig)) == '0));
endmodule

bind mdio_scan_master mdio_scan_checker #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .link_up(link_up), .elig(elig), .pend(pend_q), .cmd(cmd_q),
    .rdd(rdd_q), .frame_done(fdone)
);

// File: tb/mdio_scan_master_bench.sv
// Bench: PHY model on the pin, vector table of commands, directed tests.
module mdio_scan_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic [3:0]  copper_mode = 4'b1111;
    logic [3:0]  link_up;

    always #10 clk = ~clk;

    mdio_scan_master u_mdio_scan_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .copper_mode(copper_mode), .link_up(link_up)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    // PHY model state and frame log.
    logic [63:0] hist = '0;
    logic        prev_oe = 1'b0;
    int          rd_step = 0;
    logic [15:0] resp = '0;
    logic        drv = 1'b0;
    logic        sdat = 1'b1;
    logic [3:0]  link_tbl = 4'b1111;
    int          nlog = 0;
    int          contention = 0;
    logic        log_rd  [256];
    logic [4:0]  log_phy [256];
    logic [4:0]  log_reg [256];
    logic [15:0] log_dat [256];

    assign mdio_i = drv ? sdat : 1'b1;

    function automatic logic [15:0] phy_answer(input logic [4:0] p, input logic [4:0] r);
        if (r == 5'd1) return 16'h7809 | (p < 5'd4 ? {13'd0, link_tbl[p[1:0]], 2'b00} : 16'h0);
        return {3'b101, p, r, 3'b011};
    endfunction

    // Collect driven bits on rising MDC.
    initial begin
        forever begin
            @(posedge mdc);
            #1;
            if (mdio_oe) hist = {hist[62:0], mdio_o};
        end
    end

    // Decode frames and answer reads on falling MDC.
    initial begin
        forever begin
            @(negedge mdc);
            #1;
            if (drv && mdio_oe) contention++;
            if (prev_oe && !mdio_oe) begin
                if (hist[45:14] == 32'hFFFF_FFFF && hist[13:10] == 4'b0110) begin
                    log_rd[nlog % 256]  = 1'b1;
                    log_phy[nlog % 256] = hist[9:5];
                    log_reg[nlog % 256] = hist[4:0];
                    resp = phy_answer(hist[9:5], hist[4:0]);
                    log_dat[nlog % 256] = resp;
                    nlog++;
                    rd_step = 1;
                end else if (hist[63:32] == 32'hFFFF_FFFF && hist[31:28] == 4'b0101
                             && hist[17:16] == 2'b10) begin
                    log_rd[nlog % 256]  = 1'b0;
                    log_phy[nlog % 256] = hist[27:23];
                    log_reg[nlog % 256] = hist[22:18];
                    log_dat[nlog % 256] = hist[15:0];
                    nlog++;
                end
            end else if (rd_step == 1) begin
                drv = 1'b1; sdat = 1'b0; rd_step = 2;
            end else if (rd_step >= 2 && rd_step <= 17) begin
                sdat = resp[17 - rd_step]; rd_step++;
            end else if (rd_step == 18) begin
                drv = 1'b0; sdat = 1'b1; rd_step = 0;
            end
            prev_oe = mdio_oe;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do rd(2'd0, v); while (v[3]);
    endtask

    task automatic wait_frames(input int target);
        while (nlog < target) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // Stimulus/expected vectors: {rd, phy, reg, wdata, expected}.
    localparam logic [42:0] VEC [0:5] = '{
        {1'b1, 5'd3,  5'd2,  16'h0000, 16'hA313},
        {1'b0, 5'd5,  5'd9,  16'h1234, 16'h1234},
        {1'b1, 5'd31, 5'd31, 16'h0000, 16'hBFFB},
        {1'b0, 5'd30, 5'd0,  16'hFFFF, 16'hFFFF},
        {1'b1, 5'd0,  5'd0,  16'h0000, 16'hA003},
        {1'b1, 5'd2,  5'd1,  16'h0000, 16'h780D}
    };

    initial begin
        logic [31:0] v;
        logic [15:0] last_rd;
        int n0, k;
        time t0, t1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R4, R7).
        rd(2'd0, v); check(v == 32'h0, "R4 ctrl reset", v, 32'h0);
        rd(2'd1, v); check(v == 32'hF, "R4 enable reset", v, 32'hF);
        rd(2'd3, v); check(v == 32'h0, "R2 read data reset", v, 32'h0);
        check(link_up == 4'b0 && !mdio_oe, "R7 idle after reset", {27'd0, mdio_oe, link_up}, 32'h0);

        // Upper bits ignore writes (R4).
        wr(2'd1, 32'hFFFF_FFF5); rd(2'd1, v); check(v == 32'h5, "R4 enable upper bits", v, 32'h5);
        wr(2'd0, 32'hFFFF_FFF8); rd(2'd0, v); check(v == 32'h0, "R4 ctrl upper bits", v, 32'h0);
        wr(2'd1, 32'h0000_000F);

        // MDC period at both rates (R3).
        @(posedge mdc); @(posedge mdc); t0 = $time; @(posedge mdc); t1 = $time;
        check((t1 - t0) == 400, "R3 slow MDC period ns", 32'(t1 - t0), 32'd400);
        wr(2'd0, 32'h1);
        @(posedge mdc); @(posedge mdc); t0 = $time; @(posedge mdc); t1 = $time;
        check((t1 - t0) == 80, "R3 fast MDC period ns", 32'(t1 - t0), 32'd80);

        // Vector walk: fast rate, busy reported (R1, R2, R5).
        wr(2'd0, 32'h5);
        last_rd = 16'h0;
        for (int i = 0; i < 6; i++) begin
            n0 = nlog;
            wr(2'd2, {5'b0, VEC[i][42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16]});
            rd(2'd0, v); check(v[3] == 1'b1, "R5 busy after command", v, 32'h8);
            wait_idle();
            if (!VEC[i][42]) repeat (4) @(negedge clk);
            check(nlog == n0 + 1, "R1 one frame per command", nlog, n0 + 1);
            check(log_rd[n0 % 256] == VEC[i][42] && log_phy[n0 % 256] == VEC[i][41:37]
                  && log_reg[n0 % 256] == VEC[i][36:32],
                  "R1 opcode and addresses", {log_rd[n0 % 256], log_phy[n0 % 256], log_reg[n0 % 256]},
                  VEC[i][42:32]);
            rd(2'd3, v);
            if (VEC[i][42]) begin
                check(v[15:0] == VEC[i][15:0], "R1 read data", v, VEC[i][15:0]);
                last_rd = VEC[i][15:0];
            end else begin
                check(log_dat[n0 % 256] == VEC[i][15:0], "R1 write data", log_dat[n0 % 256], VEC[i][15:0]);
                check(v[15:0] == last_rd, "R2 write keeps read data", v, last_rd);
            end
        end
        check(contention == 0, "R1 pin released on read", contention, 0);

        // Busy gating and ignored command (R5, R6).
        n0 = nlog;
        wr(2'd2, 32'h0462_0000);
        wr(2'd2, 32'h0400_0000);
        rd(2'd0, v); check(v[3] == 1'b1, "R5 busy shown", v, 32'h8);
        wr(2'd0, 32'h1);
        rd(2'd0, v); check(v == 32'h1, "R5 busy hidden", v, 32'h1);
        rd(2'd2, v); check(v == 32'h0462_0000, "R6 stored command kept", v, 32'h0462_0000);
        wr(2'd0, 32'h5);
        wait_idle();
        repeat (300) @(negedge clk);
        check(nlog == n0 + 1, "R6 ignored command starts no frame", nlog, n0 + 1);
        rd(2'd3, v); check(v[15:0] == 16'hA313, "R6 data of first command", v, 32'hA313);

        // Polling order and copper gating (R7, R8).
        check(link_up == 4'b0, "R7 no polling while off", link_up, 0);
        copper_mode = 4'b1011;
        link_tbl = 4'b1111;
        n0 = nlog;
        wr(2'd0, 32'h7);
        wait_frames(n0 + 7);
        repeat (4) @(negedge clk);
        for (int j = 0; j < 6; j++) begin
            k = (j % 3 == 2) ? 3 : (j % 3);
            check(log_rd[(n0 + j) % 256] && log_reg[(n0 + j) % 256] == 5'd1
                  && log_phy[(n0 + j) % 256] == 5'(k),
                  "R7 poll order", log_phy[(n0 + j) % 256], k);
        end
        check(link_up == 4'b1011, "R8 skipped port holds link", link_up, 4'b1011);

        // Reduced enable mask with link changes (R8).
        link_tbl = 4'b1101;
        wr(2'd1, 32'h3);
        n0 = nlog;
        wait_frames(n0 + 6);
        repeat (300) @(negedge clk);
        check(link_up == 4'b1001, "R8 mask and link update", link_up, 4'b1001);
        check(log_phy[(nlog - 1) % 256] <= 5'd1 && log_phy[(nlog - 2) % 256] <= 5'd1,
              "R8 only enabled ports polled", log_phy[(nlog - 1) % 256], 1);

        // Command priority during polling (R9).
        n0 = nlog;
        wr(2'd2, 32'h04E5_0000);
        wait_idle();
        rd(2'd3, v); check(v[15:0] == 16'hA72B, "R9 command read during polling", v, 32'hA72B);
        k = -1;
        for (int j = n0; j < nlog; j++) if (log_reg[j % 256] == 5'd5) k = j;
        wait_frames(k + 2);
        check(k > 0 && log_phy[(k + 1) % 256] == (log_phy[(k - 1) % 256] ^ 5'd1),
              "R9 polling resumes at next address", log_phy[(k + 1) % 256], log_phy[(k - 1) % 256] ^ 5'd1);

        // Polling off (R7).
        wr(2'd0, 32'h5);
        repeat (400) @(negedge clk);
        n0 = nlog;
        repeat (2000) @(negedge clk);
        check(nlog == n0, "R7 polling stops", nlog, n0);
        check(link_up == 4'b1001, "R7 link kept after stop", link_up, 4'b1001);

        finish_run();
    end
endmodule